// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a 32-bit general-register processor that runs one instruction at a time. It carries each instruction through a fixed set of steps, spending one clock cycle on each step and keeping the intermediate values in dedicated temporaries. First it fetches the instruction word and forms the sequential successor address. Next it decodes the word and reads two source registers. It then computes an ALU result, an effective address or a branch target. Loads, stores and control transfers go on to a memory or completion cycle, and every instruction that writes a register ends with a write-back cycle. Register-to-register and register-immediate ALU operations, branches and jumps complete in four cycles. Loads and stores take five.

Instruction bits are numbered big-endian, so bit 0 is the most significant bit of the word. The opcode sits in bits 0..5. The first source register is in bits 6..10. Bits 11..15 hold the second source, which is also the destination for immediate ALU operations and loads. Bits 16..20 hold the destination for register-register operations. Bits 16..31 hold a 16-bit immediate that is sign-extended from bit 16, and bits 26..31 hold the function code. Instruction and data memories are separate word arrays that sit outside the core and answer reads in the same cycle. A halt opcode stops the core so that a harness can inspect memory after a program has run.

Opcodes, as 6-bit values: 0x00 register-register, with function 0x20 for add and 0x2A for signed set-less-than. 0x08 add-immediate, 0x0A set-less-than-immediate, 0x23 load word, 0x2B store word, 0x04 branch if zero, 0x05 branch if nonzero, 0x02 jump, 0x03 jump-and-link, 0x12 jump to register, 0x13 jump-and-link to register, 0x3F halt. Any other code completes as a no-op.

Top module: `mc_core`

## Requirements
- R1: While reset is held, the fetch address is 0, `halted` is low and no data write occurs. After reset is released, the first fetch reads address 0.
- R2: Each instruction's fetch drives `imem_fetch` high for one cycle with `imem_addr` equal to the PC. This address is word-aligned. An instruction that does not transfer control is followed by a fetch at PC+4.
- R3: The 16-bit immediate in bits 16..31 is sign-extended from bit 16 before use. Add-immediate (0x08) writes rs1+imm, and set-less-than-immediate (0x0A) writes 1 if rs1 < imm, signed, else 0. The destination is bits 11..15.
- R4: The register-register add (opcode 0, function 0x20) writes the 32-bit wrapped sum of the two sources to the register named by bits 16..20.
- R5: Set-less-than (opcode 0, function 0x2A) writes 1 when the first source is less than the second as signed values, otherwise 0.
- R6: Register 0 always reads as zero. ALU, load and link writes aimed at it are discarded.
- R7: Load (0x23) and store (0x2B) use the address rs1 + sign-extended immediate. A store writes the register in bits 11..15 to that word. A load writes the word read there into the register in bits 11..15. A read and a write never occur in the same cycle.
- R8: Branch-if-zero (0x04) and branch-if-nonzero (0x05) test rs1 against zero. When the test is true, the next fetch is at PC+4+imm; otherwise it is at PC+4.
- R9: Jump (0x02) and jump-and-link (0x03) continue at PC+4 plus the sign-extended 26-bit offset in bits 6..31. Jump-and-link also writes PC+4 to register 31.
- R10: Jump-to-register (0x12) continues at the value of rs1. Jump-and-link-to-register (0x13) does the same and also writes PC+4 to register 31, using the value rs1 had before the link write.
- R11: ALU operations, branches and jumps take four cycles from fetch to the next fetch. Loads and stores take five.
- R12: Opcode 0x3F raises `halted`, which stays high until reset. While halted, the core makes no fetch and no data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (the PC) |
| imem_fetch | output | 1 | High in the fetch cycle of each instruction |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, available in the same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data write strobe, one cycle per store |
| dmem_re | output | 1 | Data read strobe, one cycle per load |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, available in the same cycle |
| halted | output | 1 | Core has executed a halt instruction |

## Verification
The bench targets the signed edges of the compare paths. The cases are minus one against one, equal operands, and a negative register against a positive immediate; a compare done unsigned, or an immediate zero-extended, returns the wrong 0 or 1 and corrupts positive-overflow sums. It aims writes at register 0 from an add, an add-immediate and a load, then stores register 0, so a design that lets any of those writes through stores a nonzero word. Taken and untaken branches, jumps with and without a link, and register jumps are checked through the full sequence of fetch addresses, which exposes a target taken from the wrong base, a link value off by four, or a branch that goes the wrong way. Cycle spacing between fetches and silence after halt are measured directly, so a skipped or extra step shows up as a wrong interval.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int NREGS  = 32;
  localparam int RIDX_W = $clog2(NREGS);
  localparam int OPC_W  = 6;
  localparam int IMM_W  = 16;
  localparam int OFF_W  = 26;
  localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(NREGS - 1);

  localparam logic [OPC_W-1:0] OPC_REGREG = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JMP    = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JMPL   = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BRZ    = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BRNZ   = 6'h05;
  localparam logic [OPC_W-1:0] OPC_ADDI   = 6'h08;
  localparam logic [OPC_W-1:0] OPC_SLTI   = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_JREG   = 6'h12;
  localparam logic [OPC_W-1:0] OPC_JREGL  = 6'h13;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE  = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_STOP   = 6'h3F;
  localparam logic [5:0]       FN_ADD     = 6'h20;
  localparam logic [5:0]       FN_SLT     = 6'h2A;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WBACK, ST_HALT
  } step_e;

  typedef enum logic [2:0] {
    CL_NOP, CL_REGREG, CL_REGIMM, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP, CL_STOP
  } iclass_e;

  typedef enum logic {AS_ADD, AS_SLT} alu_sel_e;

  typedef struct packed {
    iclass_e           cls;
    alu_sel_e          alu;
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic [RIDX_W-1:0] rd;
    logic              wr;
    logic              link;
    logic              via_reg;
    logic              on_nonzero;
    logic [IMM_W-1:0]  imm;
    logic [OFF_W-1:0]  off;
  } dec_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sext_off(input logic [OFF_W-1:0] v);
    return {{(XLEN-OFF_W){v[OFF_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_fn(input alu_sel_e sel,
                                             input logic [XLEN-1:0] x,
                                             input logic [XLEN-1:0] y);
    logic [XLEN-1:0] r;
    if (sel == AS_SLT) r = ($signed(x) < $signed(y)) ? XLEN'(1) : '0;
    else               r = x + y;
    return r;
  endfunction
endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [XLEN-1:0] ir,
  output dec_t            dec
);
  // Big-endian numbering: field bits k..m sit at ir[XLEN-1-k : XLEN-1-m].
  logic [OPC_W-1:0] opc;
  logic [5:0]       fn;
  logic [RIDX_W-1:0] fld_s, fld_t, fld_d;

  assign opc   = ir[XLEN-1 -: OPC_W];
  assign fld_s = ir[XLEN-1-OPC_W -: RIDX_W];
  assign fld_t = ir[XLEN-1-OPC_W-RIDX_W -: RIDX_W];
  assign fld_d = ir[XLEN-1-OPC_W-2*RIDX_W -: RIDX_W];
  assign fn    = ir[5:0];

  always_comb begin
    dec            = '0;
    dec.rs1        = fld_s;
    dec.rs2        = fld_t;
    dec.imm        = ir[IMM_W-1:0];
    dec.off        = ir[OFF_W-1:0];
    dec.cls        = CL_NOP;
    dec.alu        = AS_ADD;
    dec.rd         = fld_t;
    unique case (opc)
      OPC_REGREG: begin
        dec.rd = fld_d;
        if (fn == FN_ADD)      begin dec.cls = CL_REGREG; dec.wr = 1'b1; end
        else if (fn == FN_SLT) begin dec.cls = CL_REGREG; dec.wr = 1'b1; dec.alu = AS_SLT; end
      end
      OPC_ADDI:  begin dec.cls = CL_REGIMM; dec.wr = 1'b1; end
      OPC_SLTI:  begin dec.cls = CL_REGIMM; dec.wr = 1'b1; dec.alu = AS_SLT; end
      OPC_LOAD:  begin dec.cls = CL_LOAD;   dec.wr = 1'b1; end
      OPC_STORE: dec.cls = CL_STORE;
      OPC_BRZ:   dec.cls = CL_BRANCH;
      OPC_BRNZ:  begin dec.cls = CL_BRANCH; dec.on_nonzero = 1'b1; end
      OPC_JMP:   dec.cls = CL_JUMP;
      OPC_JMPL:  begin dec.cls = CL_JUMP; dec.link = 1'b1; dec.rd = LINK_REG; end
      OPC_JREG:  begin dec.cls = CL_JUMP; dec.via_reg = 1'b1; end
      OPC_JREGL: begin dec.cls = CL_JUMP; dec.via_reg = 1'b1; dec.link = 1'b1; dec.rd = LINK_REG; end
      OPC_STOP:  dec.cls = CL_STOP;
      default:   dec.cls = CL_NOP;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int DEPTH = NREGS,
  parameter int W     = XLEN,
  localparam int AW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    if (g == 0) begin : g_zero
      assign cells[g] = '0;
    end else begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cells[g] <= '0;
        else if (we && wa == AW'(g))       cells[g] <= wd;
      end
    end
  end

  assign rd1 = cells[ra1];
  assign rd2 = cells[ra2];
endmodule

// File: rtl/mc_exec.sv
module mc_exec
  import mc_pkg::*;
(
  input  dec_t            dec,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] npc,
  output logic [XLEN-1:0] result,
  output logic            cond
);
  always_comb begin
    result = '0;
    cond   = 1'b0;
    unique case (dec.cls)
      CL_LOAD, CL_STORE: result = a + imm;
      CL_REGREG:         result = alu_fn(dec.alu, a, b);
      CL_REGIMM:         result = alu_fn(dec.alu, a, imm);
      CL_BRANCH: begin
        result = npc + imm;
        cond   = dec.on_nonzero ? (a != '0) : (a == '0);
      end
      CL_JUMP: begin
        result = dec.via_reg ? a : npc + sext_off(dec.off);
        cond   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
)(
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  output logic            imem_fetch,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            halted
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  step_e           step_q;
  logic [XLEN-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_q, lmd_q;
  logic            cond_q;

  dec_t            dec;
  logic [XLEN-1:0] rs1_val, rs2_val, ex_result;
  logic            ex_cond;

  // Named internal events
  logic              at_fetch, at_decode, at_exec, at_mem, at_wback;
  logic              wb_en;
  logic [RIDX_W-1:0] wb_addr;
  logic [XLEN-1:0]   wb_data;
  logic              link_wr;
  logic              ctl_done;

  assign at_fetch  = (step_q == ST_FETCH);
  assign at_decode = (step_q == ST_DECODE);
  assign at_exec   = (step_q == ST_EXEC);
  assign at_mem    = (step_q == ST_MEM);
  assign at_wback  = (step_q == ST_WBACK);

  mc_decode u_dec (.ir(ir_q), .dec(dec));

  mc_regfile #(.DEPTH(NREGS), .W(XLEN)) u_rf (
    .clk (clk),
    .rst_n(rst_n),
    .ra1 (dec.rs1),
    .ra2 (dec.rs2),
    .rd1 (rs1_val),
    .rd2 (rs2_val),
    .we  (wb_en),
    .wa  (wb_addr),
    .wd  (wb_data)
  );

  mc_exec u_ex (
    .dec   (dec),
    .a     (a_q),
    .b     (b_q),
    .imm   (imm_q),
    .npc   (npc_q),
    .result(ex_result),
    .cond  (ex_cond)
  );

  assign ctl_done = at_mem && (dec.cls == CL_BRANCH || dec.cls == CL_JUMP);
  assign link_wr  = ctl_done && dec.link;
  assign wb_en    = link_wr || (at_wback && dec.wr);
  assign wb_addr  = link_wr ? LINK_REG : dec.rd;
  assign wb_data  = link_wr ? npc_q : (dec.cls == CL_LOAD ? lmd_q : alu_q);

  assign imem_addr  = pc_q;
  assign imem_fetch = at_fetch;
  assign dmem_addr  = alu_q;
  assign dmem_wdata = b_q;
  assign dmem_we    = at_mem && dec.cls == CL_STORE;
  assign dmem_re    = at_mem && dec.cls == CL_LOAD;
  assign halted     = (step_q == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_FETCH;
      pc_q   <= RESET_PC;
      npc_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      imm_q  <= '0;
      alu_q  <= '0;
      lmd_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      unique case (step_q)
        ST_FETCH: begin
          ir_q   <= imem_rdata;
          npc_q  <= pc_q + STEP;
          step_q <= ST_DECODE;
        end
        ST_DECODE: begin
          a_q    <= rs1_val;
          b_q    <= rs2_val;
          imm_q  <= sext_imm(dec.imm);
          step_q <= (dec.cls == CL_STOP) ? ST_HALT : ST_EXEC;
        end
        ST_EXEC: begin
          alu_q  <= ex_result;
          cond_q <= ex_cond;
          unique case (dec.cls)
            CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP: step_q <= ST_MEM;
            default:                               step_q <= ST_WBACK;
          endcase
        end
        ST_MEM: begin
          if (dec.cls == CL_LOAD) lmd_q <= dmem_rdata;
          if (ctl_done) begin
            pc_q   <= cond_q ? alu_q : npc_q;
            step_q <= ST_FETCH;
          end else begin
            step_q <= ST_WBACK;
          end
        end
        ST_WBACK: begin
          pc_q   <= npc_q;
          step_q <= ST_FETCH;
        end
        default: step_q <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              imem_fetch,
  input logic [XLEN-1:0]   imem_addr,
  input logic              dmem_we,
  input logic              dmem_re,
  input logic              halted,
  input logic              wb_en,
  input logic [RIDX_W-1:0] rs1_idx,
  input logic [XLEN-1:0]   rs1_val
);
  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    imem_fetch |-> imem_addr[1:0] == 2'b00);                         // R2
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));                                          // R7
  AST_LOAD_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |=> wb_en);                                              // R7
  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rs1_idx == '0 |-> rs1_val == '0);                                // R6
  AST_FETCH_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    imem_fetch |=> !imem_fetch);                                     // R11
  AST_WRITE_ENDS_INSN: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> imem_fetch);                                           // R11
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);                                              // R12
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !imem_fetch && !dmem_we);                             // R12
endmodule

bind mc_core mc_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_fetch(imem_fetch),
  .imem_addr (imem_addr),
  .dmem_we   (dmem_we),
  .dmem_re   (dmem_re),
  .halted    (halted),
  .wb_en     (wb_en),
  .rs1_idx   (dec.rs1),
  .rs1_val   (rs1_val)
);

// File: tb/sim_mc_core.sv
module sim_mc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        imem_fetch, dmem_we, dmem_re, halted;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nf     = 0;
  int fetch_t [256];
  logic [31:0] fetch_a [256];
  int base = 0;

  always #2 clk = ~clk;

  mc_core u0 (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_fetch(imem_fetch), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata), .halted(halted)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && imem_fetch) begin
      fetch_t[nf % 256] = cyc;
      fetch_a[nf % 256] = imem_addr;
      nf = nf + 1;
    end
  end

  // Encoders following the field layout stated in the brief
  function automatic logic [31:0] e_r(input int rd, input int rs, input int rt, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] e_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] e_j(input logic [5:0] op, input logic [25:0] off);
    return {op, off};
  endfunction

  localparam logic [31:0] STOP_W = 32'hFC00_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin imem[i] = STOP_W; dmem[i] = '0; end
  endtask

  task automatic run_prog();
    int n;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    base  = nf;
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 3000) begin @(negedge clk); n++; end
    if (!halted) check("R12 halt reached", 32'd0, 32'd1);
  endtask

  typedef struct packed {
    logic [1:0]  kind;   // 0 add, 1 slt, 2 addi, 3 slti
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 32'd5,         32'd7,         32'd12},
    '{2'd0, 32'hFFFF_FFFF, 32'd1,         32'd0},
    '{2'd0, 32'h7FFF_FFFF, 32'd1,         32'h8000_0000},
    '{2'd1, 32'hFFFF_FFFF, 32'd1,         32'd1},
    '{2'd1, 32'd1,         32'hFFFF_FFFF, 32'd0},
    '{2'd1, 32'd3,         32'd3,         32'd0},
    '{2'd2, 32'd10,        32'h0000_FFFD, 32'd7},
    '{2'd2, 32'h0000_0100, 32'h0000_7FFF, 32'h0000_80FF},
    '{2'd3, 32'hFFFF_FFF0, 32'h0000_0005, 32'd1},
    '{2'd3, 32'd5,         32'h0000_FFFF, 32'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    string tag;
    int n0;
    clear_mem();
    // R1: reset state
    @(negedge clk);
    check("R1 pc in reset", imem_addr, 32'd0);
    check("R1 halted in reset", {31'd0, halted}, 32'd0);
    check("R1 no write in reset", {31'd0, dmem_we}, 32'd0);

    // Table of ALU vectors: R3 R4 R5
    for (int v = 0; v < 10; v++) begin
      clear_mem();
      dmem[0] = VECS[v].a;
      dmem[1] = VECS[v].b;
      imem[0] = e_i(6'h23, 0, 1, 16'd0);
      imem[1] = e_i(6'h23, 0, 2, 16'd4);
      case (VECS[v].kind)
        2'd0: begin imem[2] = e_r(3, 1, 2, 6'h20); tag = "R4 add"; end
        2'd1: begin imem[2] = e_r(3, 1, 2, 6'h2A); tag = "R5 slt"; end
        2'd2: begin imem[2] = e_i(6'h08, 1, 3, VECS[v].b[15:0]); tag = "R3 addi"; end
        default: begin imem[2] = e_i(6'h0A, 1, 3, VECS[v].b[15:0]); tag = "R3 slti"; end
      endcase
      imem[3] = e_i(6'h2B, 0, 3, 16'd8);
      run_prog();
      check(tag, dmem[2], VECS[v].exp);
      if (v == 0) begin
        check("R1 first fetch at 0", fetch_a[base % 256], 32'd0);
        check("R11 load cycles", 32'(fetch_t[(base+1)%256] - fetch_t[base%256]), 32'd5);
        check("R11 alu cycles", 32'(fetch_t[(base+3)%256] - fetch_t[(base+2)%256]), 32'd4);
        check("R11 store cycles", 32'(fetch_t[(base+4)%256] - fetch_t[(base+3)%256]), 32'd5);
        check("R2 sequential fetch", fetch_a[(base+1)%256], 32'd4);
      end
    end

    // R6 register zero, R7 addressing with negative displacement
    clear_mem();
    dmem[0] = 32'h0000_1234;
    imem[0] = e_i(6'h08, 0, 1, 16'd9);
    imem[1] = e_r(0, 1, 1, 6'h20);
    imem[2] = e_i(6'h08, 1, 0, 16'd5);
    imem[3] = e_i(6'h23, 0, 0, 16'd0);
    imem[4] = e_i(6'h2B, 0, 0, 16'd4);
    imem[5] = e_i(6'h08, 0, 4, 16'd16);
    imem[6] = e_i(6'h2B, 4, 1, 16'hFFFC);
    imem[7] = e_i(6'h23, 4, 5, 16'hFFF0);
    imem[8] = e_i(6'h2B, 0, 5, 16'd8);
    run_prog();
    check("R6 r0 stays zero", dmem[1], 32'd0);
    check("R7 store neg disp", dmem[3], 32'd9);
    check("R7 load dest field", dmem[2], 32'h0000_1234);

    // R8 branches
    clear_mem();
    imem[0]  = e_i(6'h08, 0, 1, 16'd0);
    imem[1]  = e_i(6'h04, 1, 0, 16'd4);
    imem[2]  = e_i(6'h08, 0, 3, 16'd99);
    imem[3]  = e_i(6'h05, 1, 0, 16'd4);
    imem[4]  = e_i(6'h08, 0, 4, 16'd7);
    imem[5]  = e_i(6'h05, 4, 0, 16'd4);
    imem[6]  = e_i(6'h08, 0, 3, 16'd55);
    imem[7]  = e_i(6'h08, 0, 5, 16'hFFF8);
    imem[8]  = e_i(6'h2B, 0, 3, 16'd0);
    imem[9]  = e_i(6'h2B, 0, 4, 16'd4);
    imem[10] = e_i(6'h2B, 0, 5, 16'd8);
    run_prog();
    check("R8 skipped writes", dmem[0], 32'd0);
    check("R8 fallthrough", dmem[1], 32'd7);
    check("R3 negative imm", dmem[2], 32'hFFFF_FFF8);
    check("R11 branch cycles", 32'(fetch_t[(base+2)%256] - fetch_t[(base+1)%256]), 32'd4);
    begin
      logic [31:0] exp_b [10] = '{0, 4, 12, 16, 20, 28, 32, 36, 40, 44};
      for (int i = 0; i < 10; i++)
        check("R8 fetch order", fetch_a[(base+i)%256], exp_b[i]);
    end

    // R9 R10 jumps
    clear_mem();
    imem[0]  = e_j(6'h02, 26'd8);
    imem[1]  = e_i(6'h08, 0, 3, 16'd1);
    imem[2]  = e_i(6'h08, 0, 3, 16'd2);
    imem[3]  = e_j(6'h03, 26'd8);
    imem[4]  = e_i(6'h08, 0, 3, 16'd3);
    imem[5]  = e_i(6'h08, 0, 3, 16'd4);
    imem[6]  = e_i(6'h2B, 0, 31, 16'd0);
    imem[7]  = e_i(6'h08, 0, 6, 16'd48);
    imem[8]  = e_i(6'h13, 6, 0, 16'd0);
    imem[9]  = e_i(6'h08, 0, 3, 16'd5);
    imem[10] = e_i(6'h08, 0, 3, 16'd5);
    imem[11] = e_i(6'h08, 0, 3, 16'd5);
    imem[12] = e_i(6'h2B, 0, 31, 16'd4);
    imem[13] = e_i(6'h08, 0, 7, 16'd64);
    imem[14] = e_i(6'h12, 7, 0, 16'd0);
    imem[15] = e_i(6'h08, 0, 3, 16'd6);
    imem[16] = e_i(6'h2B, 0, 3, 16'd8);
    run_prog();
    check("R9 link value", dmem[0], 32'd16);
    check("R10 reg link value", dmem[1], 32'd36);
    check("R10 skipped code", dmem[2], 32'd0);
    check("R11 jump cycles", 32'(fetch_t[(base+1)%256] - fetch_t[base%256]), 32'd4);
    begin
      logic [31:0] exp_j [10] = '{0, 12, 24, 28, 32, 48, 52, 56, 64, 68};
      for (int i = 0; i < 10; i++)
        check("R9 R10 fetch order", fetch_a[(base+i)%256], exp_j[i]);
    end

    // R12 halt holds and stays quiet
    n0 = nf;
    repeat (20) @(negedge clk);
    check("R12 no fetch after halt", 32'(nf), 32'(n0));
    check("R12 halted sticky", {31'd0, halted}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule